// File: doc/BRIEF.md
# Sleep-Mode Bus and Switch Wake-Up Qualifier

This block watches a single-wire vehicle bus and a local wake switch while the transceiver sleeps, and decides when either source has made a genuine wake-up request. It does not see analog levels. Its inputs are digitized comparator flags: the bus is below the pre-wake low threshold, the bus is dominant, the bus is above the pre-wake high threshold, and the wake pin is low. All filter times are counted in periods of a `tick` strobe supplied by the surrounding logic.

A remote request needs three things in order. The bus must fall into the pre-wake region, which turns the receiver on. The bus must then stay dominant for a qualified time. Finally the bus must rise out of the pre-wake region. A monitoring window bounds how long the receiver may stay on. If the window expires on a floating bus, the receiver switches off and the bus must sit above the pre-wake high threshold before it can be re-armed. If it expires on a bus stuck dominant, the receiver also switches off, but the next rise wakes the node at once.

A local request is a falling edge on the wake pin followed by a low held for the filter time. A pin held low forever produces only one wake. A new one needs the pin high for a minimum time first. Both kinds of request come out as single-cycle pulses. The mode controller drives `sleep_en`, and the block is held idle whenever that input is low.

Remote detector states and transitions:
- ARMED → MONITOR on a falling edge into the pre-wake region.
- MONITOR → FIRE on a rise after a qualified dominant period.
- MONITOR → ARMED on a rise without one.
- MONITOR → STUCK when the window expires while dominant.
- MONITOR → REARM when the window expires while floating.
- STUCK → FIRE on a rise.
- REARM → ARMED after the bus has been held high long enough.
- FIRE → DONE.
- DONE holds until sleep is left.

Local detector states and transitions:
- REARM → ARMED after the pin has been held high long enough.
- REARM → LATCHED if the pin goes low before then.
- ARMED → FILTER on a falling edge.
- FILTER → ARMED if the pin rises early.
- FILTER → FIRE when the filter time is met.
- FIRE → LATCHED.
- LATCHED → REARM when the pin goes high.

Top module: `lin_wake_qualifier`

## Requirements
- R1: After reset, `remote_wake`, `local_wake` and `rx_enable` are all 0.
- R2: In sleep with the remote detector armed, a 0→1 change of `bus_low` sets `rx_enable` to 1 within 2 cycles.
- R3: When `bus_dom` has been 1 for at least `DOM_TICKS` ticks within one monitoring phase and `bus_low` then returns to 0, exactly one `remote_wake` pulse follows within 2 cycles.
- R4: A dominant period shorter than `DOM_TICKS` ticks followed by `bus_low` returning to 0 gives no `remote_wake`, clears `rx_enable`, and leaves the detector armed for the next falling edge.
- R5: If `MON_TICKS` ticks pass in the monitoring phase while the bus is low but not dominant, `rx_enable` drops with no wake. A later fall of `bus_low` turns the receiver on only after `bus_high` has been held 1 for `REARM_TICKS` consecutive ticks.
- R6: If the monitoring window expires while `bus_dom` is 1, `rx_enable` drops with no wake, and the next 1→0 change of `bus_low` gives one `remote_wake` pulse.
- R7: A 0→1 change of `wake_low` held for `WAKE_TICKS` ticks gives exactly one `local_wake` pulse. A shorter low gives none.
- R8: A `wake_low` held at 1 produces no further `local_wake`. A high period shorter than `WAKE_HIGH_TICKS` ticks does not re-arm the detector. A high period at least that long re-arms it, so that the next fall starts the filter again.
- R9: Each of `remote_wake` and `local_wake` is high for exactly one cycle per wake.
- R10: While `sleep_en` is 0 (from the second cycle on), all three outputs are 0 whatever the inputs do. On every entry to sleep the local detector starts in its high-time re-arm state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle time base strobe for all filter counts |
| sleep_en | input | 1 | 1 while the mode controller is in sleep mode |
| bus_low | input | 1 | 1 when the bus is below the pre-wake low threshold |
| bus_dom | input | 1 | 1 when the bus is at the dominant level |
| bus_high | input | 1 | 1 when the bus is above the pre-wake high threshold |
| wake_low | input | 1 | 1 when the local wake pin is low |
| remote_wake | output | 1 | One-cycle pulse on a qualified bus wake-up |
| local_wake | output | 1 | One-cycle pulse on a qualified switch wake-up |
| rx_enable | output | 1 | Bus receiver enable during the monitoring phase |

## Verification
The bus detector is driven with four bus patterns:
- A long dominant pulse, which separates a qualified wake from noise.
- A short dominant pulse, which checks that the dominant filter discards it and returns to the armed state.
- A floating pre-wake level held past the window, which checks the receiver shut-off and that short and long high periods re-arm differently.
- A dominant level held past the window, which checks the immediate wake on release.

The wake pin is driven with:
- A long low and a short low, to check the filter threshold.
- A continuous low, to check that no repeated wake occurs.
- Short and long high gaps, to check the re-arm timing.

A further pass toggles all inputs outside sleep to show that they are ignored there.

// File: rtl/lwq_pkg.sv
package lwq_pkg;

    typedef enum logic [2:0] {
        R_ARMED,
        R_MONITOR,
        R_FIRE,
        R_DONE,
        R_STUCK,
        R_REARM
    } rmt_state_e;

    typedef enum logic [2:0] {
        L_REARM,
        L_ARMED,
        L_FILTER,
        L_FIRE,
        L_LATCHED
    } loc_state_e;

endpackage

// File: rtl/lwq_tick_timer.sv
// Saturating tick counter: cleared while idle, done once LIMIT ticks seen.
module lwq_tick_timer #(
    parameter int unsigned LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam int unsigned CW = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (tick && (cnt != LIM)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = run && (cnt == LIM);

endmodule

// File: rtl/lwq_remote_fsm.sv
// Bus-side wake qualifier: edge into pre-wake, dominant filter, window.
module lwq_remote_fsm
    import lwq_pkg::*;
#(
    parameter int unsigned DOM_TICKS   = 6,
    parameter int unsigned MON_TICKS   = 40,
    parameter int unsigned REARM_TICKS = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic sleep_en,
    input  logic bus_low,
    input  logic bus_dom,
    input  logic bus_high,
    output logic remote_wake,
    output logic rx_enable
);
    rmt_state_e state, nxt;
    logic       prev_low;
    logic       dom_seen;
    logic       mon_done, dom_done, rearm_done;
    logic       qualified;
    logic       fall_edge;

    lwq_tick_timer #(.LIMIT(MON_TICKS)) u_mon_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (state == R_MONITOR),
        .tick (tick),
        .done (mon_done)
    );

    lwq_tick_timer #(.LIMIT(DOM_TICKS)) u_dom_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .run  ((state == R_MONITOR) && bus_dom),
        .tick (tick),
        .done (dom_done)
    );

    lwq_tick_timer #(.LIMIT(REARM_TICKS)) u_rearm_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .run  ((state == R_REARM) && bus_high),
        .tick (tick),
        .done (rearm_done)
    );

    assign qualified = dom_seen || dom_done;
    assign fall_edge = bus_low && !prev_low;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_low <= 1'b0;
            dom_seen <= 1'b0;
        end else begin
            prev_low <= bus_low;
            if (state != R_MONITOR) begin
                dom_seen <= 1'b0;
            end else if (dom_done) begin
                dom_seen <= 1'b1;
            end
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= R_ARMED;
        end else if (!sleep_en) begin
            state <= R_ARMED;
        end else begin
            state <= nxt;
        end
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            R_ARMED: begin
                if (fall_edge) nxt = R_MONITOR;
            end
            R_MONITOR: begin
                if (!bus_low) begin
                    nxt = qualified ? R_FIRE : R_ARMED;
                end else if (mon_done) begin
                    nxt = bus_dom ? R_STUCK : R_REARM;
                end
            end
            R_FIRE:  nxt = R_DONE;
            R_DONE:  nxt = R_DONE;
            R_STUCK: begin
                if (!bus_low) nxt = R_FIRE;
            end
            R_REARM: begin
                if (rearm_done) nxt = R_ARMED;
            end
            default: nxt = R_ARMED;
        endcase
    end

    // Outputs
    always_comb begin
        remote_wake = (state == R_FIRE);
        rx_enable   = (state == R_MONITOR);
    end

endmodule

// File: rtl/lwq_local_fsm.sv
// Switch-side wake qualifier: falling edge, low filter, high re-arm time.
module lwq_local_fsm
    import lwq_pkg::*;
#(
    parameter int unsigned WAKE_TICKS      = 4,
    parameter int unsigned WAKE_HIGH_TICKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic sleep_en,
    input  logic wake_low,
    output logic local_wake
);
    loc_state_e state, nxt;
    logic       prev_wake;
    logic       filt_done, high_done;
    logic       fall_edge;

    lwq_tick_timer #(.LIMIT(WAKE_TICKS)) u_filt_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .run  ((state == L_FILTER) && wake_low),
        .tick (tick),
        .done (filt_done)
    );

    lwq_tick_timer #(.LIMIT(WAKE_HIGH_TICKS)) u_high_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .run  ((state == L_REARM) && !wake_low),
        .tick (tick),
        .done (high_done)
    );

    assign fall_edge = wake_low && !prev_wake;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_wake <= 1'b0;
        end else begin
            prev_wake <= wake_low;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= L_REARM;
        end else if (!sleep_en) begin
            state <= L_REARM;
        end else begin
            state <= nxt;
        end
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            L_REARM: begin
                if (wake_low)       nxt = L_LATCHED;
                else if (high_done) nxt = L_ARMED;
            end
            L_ARMED: begin
                if (fall_edge) nxt = L_FILTER;
            end
            L_FILTER: begin
                if (!wake_low)      nxt = L_ARMED;
                else if (filt_done) nxt = L_FIRE;
            end
            L_FIRE: nxt = L_LATCHED;
            L_LATCHED: begin
                if (!wake_low) nxt = L_REARM;
            end
            default: nxt = L_REARM;
        endcase
    end

    // Outputs
    always_comb begin
        local_wake = (state == L_FIRE);
    end

endmodule

// File: rtl/lin_wake_qualifier.sv
module lin_wake_qualifier #(
    parameter int unsigned DOM_TICKS       = 6,
    parameter int unsigned MON_TICKS       = 40,
    parameter int unsigned REARM_TICKS     = 5,
    parameter int unsigned WAKE_TICKS      = 4,
    parameter int unsigned WAKE_HIGH_TICKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic sleep_en,
    input  logic bus_low,
    input  logic bus_dom,
    input  logic bus_high,
    input  logic wake_low,
    output logic remote_wake,
    output logic local_wake,
    output logic rx_enable
);

    lwq_remote_fsm #(
        .DOM_TICKS  (DOM_TICKS),
        .MON_TICKS  (MON_TICKS),
        .REARM_TICKS(REARM_TICKS)
    ) u_remote (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .sleep_en   (sleep_en),
        .bus_low    (bus_low),
        .bus_dom    (bus_dom),
        .bus_high   (bus_high),
        .remote_wake(remote_wake),
        .rx_enable  (rx_enable)
    );

    lwq_local_fsm #(
        .WAKE_TICKS     (WAKE_TICKS),
        .WAKE_HIGH_TICKS(WAKE_HIGH_TICKS)
    ) u_local (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .sleep_en  (sleep_en),
        .wake_low  (wake_low),
        .local_wake(local_wake)
    );

endmodule

// File: rtl/lwq_checker.sv
module lwq_checker (
    input logic clk,
    input logic rst_n,
    input logic sleep_en,
    input logic bus_low,
    input logic wake_low,
    input logic remote_wake,
    input logic local_wake,
    input logic rx_enable
);

    // R9: remote pulse lasts one cycle
    p_remote_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        remote_wake |=> !remote_wake);

    // R9: local pulse lasts one cycle
    p_local_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        local_wake |=> !local_wake);

    // R10: idle outside sleep
    p_idle_outside_sleep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep_en ##1 !sleep_en) |-> (!remote_wake && !local_wake && !rx_enable));

    // R3: a remote wake follows the bus leaving the pre-wake region
    p_remote_after_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        remote_wake |-> !$past(bus_low));

    // R2: the receiver turns on only after the bus went low
    p_rx_on_after_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_enable) |-> $past(bus_low));

    // R7: a local wake follows a held-low pin
    p_local_after_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        local_wake |-> $past(wake_low));

endmodule

bind lin_wake_qualifier lwq_checker chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sleep_en   (sleep_en),
    .bus_low    (bus_low),
    .wake_low   (wake_low),
    .remote_wake(remote_wake),
    .local_wake (local_wake),
    .rx_enable  (rx_enable)
);

// File: tb/lin_wake_qualifier_tb_top.sv
`timescale 1ns/1ps
module lin_wake_qualifier_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic sleep_en = 1'b0;
    logic bus_low = 1'b0;
    logic bus_dom = 1'b0;
    logic bus_high = 1'b1;
    logic wake_low = 1'b0;
    logic remote_wake, local_wake, rx_enable;

    int checks = 0;
    int fails = 0;
    int rw_cnt = 0;
    int lw_cnt = 0;
    int rw_run = 0;
    int lw_run = 0;
    int rw_max = 0;
    int lw_max = 0;
    logic [1:0] div = 2'd0;

    always #10 clk = ~clk;   // 50 MHz

    // tick every 4 cycles
    always @(posedge clk) begin
        div  <= div + 2'd1;
        tick <= (div == 2'd3);
    end

    // pulse counters and width tracking
    always @(posedge clk) begin
        if (remote_wake) begin
            rw_cnt = rw_cnt + 1;
            rw_run = rw_run + 1;
            if (rw_run > rw_max) rw_max = rw_run;
        end else begin
            rw_run = 0;
        end
        if (local_wake) begin
            lw_cnt = lw_cnt + 1;
            lw_run = lw_run + 1;
            if (lw_run > lw_max) lw_max = lw_run;
        end else begin
            lw_run = 0;
        end
    end

    lin_wake_qualifier #(
        .DOM_TICKS(6), .MON_TICKS(40), .REARM_TICKS(5),
        .WAKE_TICKS(4), .WAKE_HIGH_TICKS(3)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .sleep_en(sleep_en),
        .bus_low(bus_low), .bus_dom(bus_dom), .bus_high(bus_high),
        .wake_low(wake_low), .remote_wake(remote_wake),
        .local_wake(local_wake), .rx_enable(rx_enable)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // 0 high, 1 mid recessive, 2 floating pre-wake, 3 dominant
    task automatic set_bus(input int kind);
        @(negedge clk);
        bus_high = (kind == 0);
        bus_low  = (kind >= 2);
        bus_dom  = (kind == 3);
    endtask

    task automatic reenter_sleep();
        @(negedge clk);
        sleep_en = 1'b0;
        wait_cyc(3);
        sleep_en = 1'b1;
        wait_cyc(30);
    endtask

    task automatic t_reset();
        wait_cyc(2);
        check(remote_wake == 0, "R1 remote_wake", remote_wake, 0);
        check(local_wake == 0, "R1 local_wake", local_wake, 0);
        check(rx_enable == 0, "R1 rx_enable", rx_enable, 0);
    endtask

    task automatic t_not_sleep();
        int r0, l0;
        r0 = rw_cnt; l0 = lw_cnt;
        set_bus(3); wake_low = 1'b1;
        wait_cyc(5);
        check(rx_enable == 0, "R10 rx off outside sleep", rx_enable, 0);
        wait_cyc(40);
        set_bus(0); wake_low = 1'b0;
        wait_cyc(10);
        check(rw_cnt == r0, "R10 no remote outside sleep", rw_cnt - r0, 0);
        check(lw_cnt == l0, "R10 no local outside sleep", lw_cnt - l0, 0);
    endtask

    task automatic t_remote_good();
        int r0;
        r0 = rw_cnt;
        set_bus(3);
        wait_cyc(3);
        check(rx_enable == 1, "R2 rx on after fall", rx_enable, 1);
        wait_cyc(40);
        set_bus(0);
        wait_cyc(4);
        check(rw_cnt == r0 + 1, "R3 one remote wake", rw_cnt - r0, 1);
        check(rx_enable == 0, "R3 rx off after wake", rx_enable, 0);
    endtask

    task automatic t_remote_short();
        int r0;
        r0 = rw_cnt;
        set_bus(3);
        wait_cyc(12);
        set_bus(0);
        wait_cyc(10);
        check(rw_cnt == r0, "R4 short dominant discarded", rw_cnt - r0, 0);
        check(rx_enable == 0, "R4 rx off after short", rx_enable, 0);
        set_bus(3);
        wait_cyc(3);
        check(rx_enable == 1, "R4 re-armed after short", rx_enable, 1);
        wait_cyc(40);
        set_bus(0);
        wait_cyc(4);
        check(rw_cnt == r0 + 1, "R4 later long pulse wakes", rw_cnt - r0, 1);
    endtask

    task automatic t_float_timeout();
        int r0;
        r0 = rw_cnt;
        set_bus(2);
        wait_cyc(3);
        check(rx_enable == 1, "R5 rx on in floating", rx_enable, 1);
        wait_cyc(220);
        check(rx_enable == 0, "R5 rx off after window", rx_enable, 0);
        check(rw_cnt == r0, "R5 no wake on floating", rw_cnt - r0, 0);
        set_bus(1); wait_cyc(10);
        set_bus(2); wait_cyc(3);
        check(rx_enable == 0, "R5 not re-armed without high", rx_enable, 0);
        set_bus(0); wait_cyc(8);
        set_bus(2); wait_cyc(3);
        check(rx_enable == 0, "R5 short high does not re-arm", rx_enable, 0);
        set_bus(0); wait_cyc(40);
        set_bus(2); wait_cyc(3);
        check(rx_enable == 1, "R5 long high re-arms", rx_enable, 1);
        set_bus(0); wait_cyc(6);
        check(rw_cnt == r0, "R5 unqualified rise no wake", rw_cnt - r0, 0);
    endtask

    task automatic t_stuck();
        int r0;
        r0 = rw_cnt;
        set_bus(3);
        wait_cyc(220);
        check(rx_enable == 0, "R6 rx off on stuck dominant", rx_enable, 0);
        check(rw_cnt == r0, "R6 no wake while stuck", rw_cnt - r0, 0);
        set_bus(0);
        wait_cyc(4);
        check(rw_cnt == r0 + 1, "R6 immediate wake on release", rw_cnt - r0, 1);
    endtask

    task automatic t_local();
        int l0;
        l0 = lw_cnt;
        @(negedge clk); wake_low = 1'b1;
        wait_cyc(30);
        check(lw_cnt == l0 + 1, "R7 local wake on long low", lw_cnt - l0, 1);
        wait_cyc(100);
        check(lw_cnt == l0 + 1, "R8 no repeat while held low", lw_cnt - l0, 1);
        @(negedge clk); wake_low = 1'b0;
        wait_cyc(4);
        @(negedge clk); wake_low = 1'b1;
        wait_cyc(30);
        check(lw_cnt == l0 + 1, "R8 short high does not re-arm", lw_cnt - l0, 1);
        @(negedge clk); wake_low = 1'b0;
        wait_cyc(24);
        @(negedge clk); wake_low = 1'b1;
        wait_cyc(30);
        check(lw_cnt == l0 + 2, "R8 long high re-arms filter", lw_cnt - l0, 2);
    endtask

    task automatic t_local_short();
        int l0;
        l0 = lw_cnt;
        @(negedge clk); wake_low = 1'b0;
        wait_cyc(24);
        @(negedge clk); wake_low = 1'b1;
        wait_cyc(8);
        @(negedge clk); wake_low = 1'b0;
        wait_cyc(24);
        check(lw_cnt == l0, "R7 short low no wake", lw_cnt - l0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R1..all actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        wait_cyc(3);
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        wait_cyc(2);
        t_reset();
        t_not_sleep();
        reenter_sleep();
        t_remote_good();
        reenter_sleep();
        t_remote_short();
        reenter_sleep();
        t_float_timeout();
        reenter_sleep();
        t_stuck();
        reenter_sleep();
        t_local();
        t_local_short();
        @(negedge clk); sleep_en = 1'b0;
        wait_cyc(3);
        check(rx_enable == 0 && remote_wake == 0, "R10 idle after leaving sleep", rx_enable, 0);
        check(rw_max == 1, "R9 remote pulse width", rw_max, 1);
        check(lw_max == 1, "R9 local pulse width", lw_max, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule